// File: doc/BRIEF.md
# ATA Task File Register Bank

This block holds the byte-wide host-visible registers of a parallel ATA port on which two devices share one cable. Host writes to the command-block registers land in both device slots at once, as both devices see the same bus cycle. Each address or count register keeps a two-deep history: a write pushes the old value into a previous copy before storing the new one. A high-order-byte select bit in the device control register chooses which copy a read returns, so software can read back the upper half of a 48-bit address.

From the stored values the block derives the selected unit, the LBA/CHS flag, and both the 28-bit and the 48-bit sector address of the selected unit. A command-register write first produces an interrupt-clear pulse and, one cycle later, a command strobe carrying the opcode. A software reset fires only when the reset bit of device control is released. It reloads both slots with their power-on signature and holds a busy status for a fixed number of cycles. Command execution and data movement belong to other blocks.

Top module: `taskfile_bank`

## Requirements
- R1: A write to register 1 (features), 2 (sector count), 3 (sector number), 4 (cylinder low) or 5 (cylinder high) is stored in both device slots. While control bit 7 is 0, a read of that address returns the new value for whichever unit is selected.
- R2: On such a write the value it replaces moves into that register's previous copy. While control bit 7 is 1, reads of addresses 1 to 5 return the previous copy.
- R3: Every accepted write to addresses 1 to 7 clears control bit 7, so that the next read returns current copies.
- R4: A write to address 6 stores the byte with bits 7 and 5 forced to 1, and a read of address 6 returns it. unitSel follows bit 4 of the stored byte.
- R5: lbaMode follows bit 6 of the device/head byte. lba28 is {devHead[3:0], cylinder high, cylinder low, sector number}, built from the current copies.
- R6: lba48 is {previous cylinder high, previous cylinder low, previous sector number, current cylinder high, current cylinder low, current sector number}.
- R7: A write to address 7 raises irqClear for one cycle after the accepting edge. cmdStrobe follows in the next cycle, with cmdOpcode equal to the written byte.
- R8: srstPulse is high for one cycle after a control write that takes bit 2 from 1 to 0. A write that takes bit 2 from 0 to 1 produces no pulse.
- R9: After the reset release edge, a read of address 7 returns 0x80 for RST_CYCLES cycles and then returns 0x50 for a disk unit or 0x00 for a packet unit. Command-block writes made while busy have no effect.
- R10: After a hard reset or a software reset, both slots hold: features 0, sector count 1, sector number 1, all previous copies 0, device/head 0xA0. Cylinder low/high are 0x00/0x00 for a disk unit and 0x14/0xEB for a packet unit.
- R11: A read of address 0 returns 0xFF. A write to address 0 changes nothing, and it leaves control bit 7 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Command-block write strobe |
| wrAddr | input | 3 | Command-block register address |
| wrData | input | 8 | Write data |
| ctlWrEn | input | 1 | Device control write strobe |
| ctlWrData | input | 8 | Device control value (bit 7 high-byte select, bit 2 reset) |
| rdAddr | input | 3 | Read address |
| rdData | output | 8 | Read data of the selected unit |
| unitSel | output | 1 | Selected unit |
| lbaMode | output | 1 | 1 for LBA addressing, 0 for CHS |
| lba28 | output | 28 | 28-bit sector address |
| lba48 | output | 48 | 48-bit sector address |
| cmdStrobe | output | 1 | Command issue pulse |
| cmdOpcode | output | 8 | Opcode valid with cmdStrobe |
| irqClear | output | 1 | Interrupt clear pulse |
| srstPulse | output | 1 | Software reset pulse |

## Verification
The assertions check on every cycle the ordering of irqClear ahead of cmdStrobe, the sources of irqClear and srstPulse, the forced bits of device/head, and the tracking of unitSel and lbaMode. They also check the busy status right after a reset release and the suppression of commands while busy. The history shifting, the effect of the high-byte select on reads, the per-unit reset signatures, the exact length of the busy window and the address assembly are shown only by the bench's scenarios. There, a behavioural model is compared with the outputs each cycle.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_DEV  = 2;
  localparam int HIST_NUM = 5;

  typedef enum logic [2:0] {
    REG_DATA    = 3'd0,
    REG_FEAT    = 3'd1,
    REG_COUNT   = 3'd2,
    REG_SECTOR  = 3'd3,
    REG_CYL_LO  = 3'd4,
    REG_CYL_HI  = 3'd5,
    REG_DEVHEAD = 3'd6,
    REG_CMD     = 3'd7
  } regSel_e;

  // history slot index = register address - 1
  localparam int H_SECTOR = 2;
  localparam int H_CYL_LO = 3;
  localparam int H_CYL_HI = 4;

  localparam logic [BYTE_W-1:0] DH_FORCED   = 8'hA0;
  localparam int                DH_UNIT     = 4;
  localparam int                DH_LBA      = 6;
  localparam logic [BYTE_W-1:0] STAT_BUSY   = 8'h80;
  localparam logic [BYTE_W-1:0] STAT_DISK   = 8'h50;
  localparam logic [BYTE_W-1:0] STAT_PACKET = 8'h00;
  localparam logic [BYTE_W-1:0] SIG_PKT_LO  = 8'h14;
  localparam logic [BYTE_W-1:0] SIG_PKT_HI  = 8'hEB;

  typedef struct packed {
    logic [HIST_NUM-1:0] histWr;
    logic                devHeadWr;
    logic                sigLoad;
    logic                hobSel;
    logic                busy;
  } tfrStrobe_t;
endpackage

// File: rtl/tfr_ctrl.sv
module tfr_ctrl
  import tfr_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              ctlWrEn,
  input  logic              ctlHobIn,
  input  logic              ctlRstIn,
  output tfrStrobe_t        strb,
  output logic              irqClear,
  output logic              cmdStrobe,
  output logic [BYTE_W-1:0] cmdOpcode,
  output logic              srstPulse
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic              hobBit, rstBit, hobNext;
  logic [CNT_W-1:0]  busyCnt;
  logic              busy, accept, fallEdge, cmdWr;
  logic [BYTE_W-1:0] pendOp;

  assign busy     = (busyCnt != '0);
  assign accept   = wrEn && !busy;
  assign fallEdge = ctlWrEn && rstBit && !ctlRstIn;
  assign cmdWr    = accept && (wrAddr == REG_CMD);

  always_comb begin
    hobNext = ctlWrEn ? ctlHobIn : hobBit;
    if (accept && (wrAddr != REG_DATA)) hobNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hobBit  <= 1'b0;
      rstBit  <= 1'b0;
      busyCnt <= '0;
    end else begin
      hobBit <= hobNext;
      if (ctlWrEn) rstBit <= ctlRstIn;
      if (fallEdge)  busyCnt <= CNT_W'(RST_CYCLES);
      else if (busy) busyCnt <= busyCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqClear  <= 1'b0;
      cmdStrobe <= 1'b0;
      pendOp    <= '0;
      cmdOpcode <= '0;
      srstPulse <= 1'b0;
    end else begin
      irqClear  <= cmdWr;
      cmdStrobe <= irqClear;
      srstPulse <= fallEdge;
      if (cmdWr)    pendOp    <= wrData;
      if (irqClear) cmdOpcode <= pendOp;
    end
  end

  for (genvar i = 0; i < HIST_NUM; i++) begin : g_hist
    assign strb.histWr[i] = accept && (wrAddr == 3'(i + 1));
  end
  assign strb.devHeadWr = accept && (wrAddr == REG_DEVHEAD);
  assign strb.sigLoad   = fallEdge;
  assign strb.hobSel    = hobBit;
  assign strb.busy      = busy;
endmodule

// File: rtl/tfr_slot.sv
module tfr_slot
  import tfr_pkg::*;
#(
  parameter bit IS_PACKET = 1'b0
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  tfrStrobe_t                       strb,
  input  logic [BYTE_W-1:0]                wrData,
  output logic [HIST_NUM-1:0][BYTE_W-1:0]  curRegs,
  output logic [HIST_NUM-1:0][BYTE_W-1:0]  prevRegs,
  output logic [BYTE_W-1:0]                devHead,
  output logic [BYTE_W-1:0]                status
);
  localparam logic [BYTE_W-1:0] SIG_LO = IS_PACKET ? SIG_PKT_LO : 8'h00;
  localparam logic [BYTE_W-1:0] SIG_HI = IS_PACKET ? SIG_PKT_HI : 8'h00;
  localparam logic [HIST_NUM-1:0][BYTE_W-1:0] SIG =
    {SIG_HI, SIG_LO, 8'h01, 8'h01, 8'h00};

  for (genvar i = 0; i < HIST_NUM; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        curRegs[i]  <= SIG[i];
        prevRegs[i] <= '0;
      end else if (strb.sigLoad) begin
        curRegs[i]  <= SIG[i];
        prevRegs[i] <= '0;
      end else if (strb.histWr[i]) begin
        prevRegs[i] <= curRegs[i];
        curRegs[i]  <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               devHead <= DH_FORCED;
    else if (strb.sigLoad)   devHead <= DH_FORCED;
    else if (strb.devHeadWr) devHead <= wrData | DH_FORCED;
  end

  assign status = strb.busy ? STAT_BUSY : (IS_PACKET ? STAT_PACKET : STAT_DISK);
endmodule

// File: rtl/tfr_datapath.sv
module tfr_datapath
  import tfr_pkg::*;
#(
  parameter logic [NUM_DEV-1:0] PACKET_MASK = 2'b10
) (
  input  logic              clk,
  input  logic              rstN,
  input  tfrStrobe_t        strb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic              unitSel,
  output logic              lbaMode,
  output logic [27:0]       lba28,
  output logic [47:0]       lba48
);
  logic [NUM_DEV-1:0][HIST_NUM-1:0][BYTE_W-1:0] curAll, prevAll;
  logic [NUM_DEV-1:0][BYTE_W-1:0]               dhAll, statAll;
  logic [HIST_NUM-1:0][BYTE_W-1:0]              selCur, selPrev;
  logic [BYTE_W-1:0]                            selDh;
  logic [2:0]                                   histIdx;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    tfr_slot #(.IS_PACKET(PACKET_MASK[d])) u_slot (
      .clk     (clk),
      .rstN    (rstN),
      .strb    (strb),
      .wrData  (wrData),
      .curRegs (curAll[d]),
      .prevRegs(prevAll[d]),
      .devHead (dhAll[d]),
      .status  (statAll[d])
    );
  end

  // both slots see identical device/head writes, slot 0 decides the unit
  assign unitSel = dhAll[0][DH_UNIT];
  assign selCur  = curAll[unitSel];
  assign selPrev = prevAll[unitSel];
  assign selDh   = dhAll[unitSel];
  assign histIdx = rdAddr - 3'd1;

  always_comb begin
    case (rdAddr)
      REG_DATA:    rdData = 8'hFF;
      REG_DEVHEAD: rdData = selDh;
      REG_CMD:     rdData = statAll[unitSel];
      default:     rdData = strb.hobSel ? selPrev[histIdx] : selCur[histIdx];
    endcase
  end

  assign lbaMode = selDh[DH_LBA];
  assign lba28   = {selDh[3:0], selCur[H_CYL_HI], selCur[H_CYL_LO], selCur[H_SECTOR]};
  assign lba48   = {selPrev[H_CYL_HI], selPrev[H_CYL_LO], selPrev[H_SECTOR],
                    selCur[H_CYL_HI], selCur[H_CYL_LO], selCur[H_SECTOR]};
endmodule

// File: rtl/taskfile_bank.sv
module taskfile_bank
  import tfr_pkg::*;
#(
  parameter int                 RST_CYCLES  = 16,
  parameter logic [NUM_DEV-1:0] PACKET_MASK = 2'b10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic        ctlWrEn,
  input  logic [7:0]  ctlWrData,
  input  logic [2:0]  rdAddr,
  output logic [7:0]  rdData,
  output logic        unitSel,
  output logic        lbaMode,
  output logic [27:0] lba28,
  output logic [47:0] lba48,
  output logic        cmdStrobe,
  output logic [7:0]  cmdOpcode,
  output logic        irqClear,
  output logic        srstPulse
);
  tfrStrobe_t strb;
  logic       ctlUnused;

  assign ctlUnused = ^{ctlWrData[6:3], ctlWrData[1:0]};

  tfr_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .ctlWrEn  (ctlWrEn),
    .ctlHobIn (ctlWrData[7]),
    .ctlRstIn (ctlWrData[2]),
    .strb     (strb),
    .irqClear (irqClear),
    .cmdStrobe(cmdStrobe),
    .cmdOpcode(cmdOpcode),
    .srstPulse(srstPulse)
  );

  tfr_datapath #(.PACKET_MASK(PACKET_MASK)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .unitSel(unitSel),
    .lbaMode(lbaMode),
    .lba28  (lba28),
    .lba48  (lba48)
  );
endmodule

// File: rtl/taskfile_bank_chk.sv
module taskfile_bank_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [2:0] wrAddr,
  input logic       ctlWrEn,
  input logic [7:0] ctlWrData,
  input logic [2:0] rdAddr,
  input logic [7:0] rdData,
  input logic       unitSel,
  input logic       lbaMode,
  input logic       irqClear,
  input logic       cmdStrobe,
  input logic       srstPulse,
  input logic       busy
);
  AST_DH_FORCED: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == 3'd6) |-> (rdData[7] && rdData[5])); // R4
  AST_UNIT_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == 3'd6) |-> (rdData[4] == unitSel)); // R4
  AST_LBA_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == 3'd6) |-> (rdData[6] == lbaMode)); // R5
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irqClear |-> $past(wrEn && wrAddr == 3'd7)); // R7
  AST_CMD_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> $past(irqClear)); // R7
  AST_SRST_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    srstPulse |-> $past(ctlWrEn && !ctlWrData[2])); // R8
  AST_SRST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    srstPulse |=> !srstPulse); // R8
  AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (srstPulse && rdAddr == 3'd7) |-> (rdData == 8'h80)); // R9
  AST_NO_CMD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && wrAddr == 3'd7) |=> !irqClear); // R9
endmodule

bind taskfile_bank taskfile_bank_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .ctlWrEn  (ctlWrEn),
  .ctlWrData(ctlWrData),
  .rdAddr   (rdAddr),
  .rdData   (rdData),
  .unitSel  (unitSel),
  .lbaMode  (lbaMode),
  .irqClear (irqClear),
  .cmdStrobe(cmdStrobe),
  .srstPulse(srstPulse),
  .busy     (strb.busy)
);

// File: tb/taskfile_bank_bench.sv
module taskfile_bank_bench;
  localparam int       RST_N  = 8;
  localparam bit [1:0] PKMASK = 2'b10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, ctlWrEn = 1'b0;
  logic [2:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0, ctlWrData = '0;
  logic [7:0] rdData, cmdOpcode;
  logic unitSel, lbaMode, cmdStrobe, irqClear, srstPulse;
  logic [27:0] lba28;
  logic [47:0] lba48;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  taskfile_bank #(.RST_CYCLES(RST_N), .PACKET_MASK(PKMASK)) u_taskfile_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .rdAddr(rdAddr), .rdData(rdData),
    .unitSel(unitSel), .lbaMode(lbaMode), .lba28(lba28), .lba48(lba48),
    .cmdStrobe(cmdStrobe), .cmdOpcode(cmdOpcode), .irqClear(irqClear),
    .srstPulse(srstPulse));

  // behavioural reference model
  logic [7:0] mCur[2][5];
  logic [7:0] mPrev[2][5];
  logic [7:0] mDh[2];
  logic mHob, mRst, mIrq, mStb, mSrst;
  int   mCnt;
  logic [7:0] mPend, mOp;

  task automatic loadSig();
    for (int d = 0; d < 2; d++) begin
      mCur[d][0] = 8'h00; mCur[d][1] = 8'h01; mCur[d][2] = 8'h01;
      mCur[d][3] = PKMASK[d] ? 8'h14 : 8'h00;
      mCur[d][4] = PKMASK[d] ? 8'hEB : 8'h00;
      for (int k = 0; k < 5; k++) mPrev[d][k] = 8'h00;
      mDh[d] = 8'hA0;
    end
  endtask

  task automatic modelReset();
    loadSig();
    mHob = 0; mRst = 0; mIrq = 0; mStb = 0; mSrst = 0; mCnt = 0;
    mPend = 0; mOp = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      bit acc, fall, cmdW;
      acc  = wrEn && (mCnt == 0);
      fall = ctlWrEn && mRst && !ctlWrData[2];
      cmdW = acc && wrAddr == 3'd7;
      mStb = mIrq;
      if (mIrq) mOp = mPend;
      mIrq = cmdW;
      if (cmdW) mPend = wrData;
      mSrst = fall;
      if (ctlWrEn) begin mHob = ctlWrData[7]; mRst = ctlWrData[2]; end
      if (acc && wrAddr != 3'd0) mHob = 1'b0;
      if (fall) begin loadSig(); mCnt = RST_N; end
      else begin
        if (mCnt > 0) mCnt = mCnt - 1;
        if (acc && wrAddr >= 3'd1 && wrAddr <= 3'd5)
          for (int d = 0; d < 2; d++) begin
            mPrev[d][wrAddr-1] = mCur[d][wrAddr-1];
            mCur[d][wrAddr-1]  = wrData;
          end
        if (acc && wrAddr == 3'd6)
          for (int d = 0; d < 2; d++) mDh[d] = wrData | 8'hA0;
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    int u;
    logic [7:0] eRd;
    logic [27:0] e28;
    logic [47:0] e48;
    string tag;
    u = mDh[0][4];
    case (rdAddr)
      3'd0: begin eRd = 8'hFF; tag = "R11 rdData"; end
      3'd6: begin eRd = mDh[u]; tag = "R4 rdData"; end
      3'd7: begin eRd = (mCnt != 0) ? 8'h80 : (PKMASK[u] ? 8'h00 : 8'h50); tag = "R9 status"; end
      default: begin
        eRd = mHob ? mPrev[u][rdAddr-1] : mCur[u][rdAddr-1];
        tag = mHob ? "R2 rdData" : "R1 rdData";
      end
    endcase
    e28 = {mDh[u][3:0], mCur[u][4], mCur[u][3], mCur[u][2]};
    e48 = {mPrev[u][4], mPrev[u][3], mPrev[u][2], mCur[u][4], mCur[u][3], mCur[u][2]};
    chk(tag, 64'(rdData), 64'(eRd));
    chk("R4 unitSel", 64'(unitSel), 64'(u));
    chk("R5 lbaMode", 64'(lbaMode), 64'(mDh[u][6]));
    chk("R5 lba28", 64'(lba28), 64'(e28));
    chk("R6 lba48", 64'(lba48), 64'(e48));
    chk("R7 irqClear", 64'(irqClear), 64'(mIrq));
    chk("R7 cmdStrobe", 64'(cmdStrobe), 64'(mStb));
    if (mStb) chk("R7 cmdOpcode", 64'(cmdOpcode), 64'(mOp));
    chk("R8 srstPulse", 64'(srstPulse), 64'(mSrst));
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
    wrEn = 0; ctlWrEn = 0;
  endtask

  task automatic blkWr(logic [2:0] a, logic [7:0] d);
    tick(); wrEn = 1; wrAddr = a; wrData = d;
  endtask

  task automatic ctlWr(logic [7:0] d);
    tick(); ctlWrEn = 1; ctlWrData = d;
  endtask

  task automatic readChk(logic [2:0] a, logic [7:0] exp, string tag);
    tick(); rdAddr = a;
    tick();
    chk(tag, 64'(rdData), 64'(exp));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    readChk(3'd0, 8'hFF, "R11 data port");
    readChk(3'd1, 8'h00, "R10 features");
    readChk(3'd2, 8'h01, "R10 count");
    readChk(3'd3, 8'h01, "R10 sector");
    readChk(3'd4, 8'h00, "R10 disk cyl lo");
    readChk(3'd6, 8'hA0, "R10 devhead");
    readChk(3'd7, 8'h50, "R9 disk status");
    ctlWr(8'h80);
    readChk(3'd2, 8'h00, "R10 prev count");
    ctlWr(8'h00);
    // history
    blkWr(3'd2, 8'h12);
    blkWr(3'd2, 8'h34);
    readChk(3'd2, 8'h34, "R1 count current");
    ctlWr(8'h80);
    readChk(3'd2, 8'h12, "R2 count previous");
    blkWr(3'd3, 8'h56);
    readChk(3'd2, 8'h34, "R3 hob cleared");
    // unit select and packet signature
    blkWr(3'd6, 8'h10);
    readChk(3'd6, 8'hB0, "R4 devhead forced");
    chk("R4 unit 1", 64'(unitSel), 64'd1);
    readChk(3'd2, 8'h34, "R1 slot 1 count");
    readChk(3'd4, 8'h14, "R10 packet cyl lo");
    readChk(3'd7, 8'h00, "R9 packet status");
    // LBA assembly
    blkWr(3'd6, 8'h4A);
    blkWr(3'd5, 8'h11);
    blkWr(3'd5, 8'h22);
    blkWr(3'd4, 8'h33);
    blkWr(3'd4, 8'h44);
    blkWr(3'd3, 8'h66);
    readChk(3'd6, 8'hEA, "R5 devhead lba");
    chk("R5 lbaMode", 64'(lbaMode), 64'd1);
    chk("R5 lba28", 64'(lba28), 64'h0A224466);
    chk("R6 lba48", 64'(lba48), 64'h113356224466);
    blkWr(3'd6, 8'h0A);
    tick();
    chk("R5 chs mode", 64'(lbaMode), 64'd0);
    // command
    blkWr(3'd7, 8'h20);
    tick();
    chk("R7 irq first", 64'(irqClear), 64'd1);
    chk("R7 no strobe yet", 64'(cmdStrobe), 64'd0);
    tick();
    chk("R7 strobe", 64'(cmdStrobe), 64'd1);
    chk("R7 opcode", 64'(cmdOpcode), 64'h20);
    blkWr(3'd7, 8'h30);
    blkWr(3'd7, 8'h31);
    tick(); tick();
    chk("R7 back-to-back opcode", 64'(cmdOpcode), 64'h31);
    // data port write ignored
    ctlWr(8'h80);
    blkWr(3'd0, 8'h99);
    readChk(3'd2, 8'h12, "R11 data write keeps hob");
    ctlWr(8'h00);
    // software reset
    ctlWr(8'h04);
    tick();
    chk("R8 no pulse on rise", 64'(srstPulse), 64'd0);
    rdAddr = 3'd7;
    ctlWr(8'h00);
    tick();
    chk("R8 pulse on fall", 64'(srstPulse), 64'd1);
    chk("R9 busy status", 64'(rdData), 64'h80);
    blkWr(3'd7, 8'h40);
    tick();
    chk("R9 cmd ignored while busy", 64'(irqClear), 64'd0);
    blkWr(3'd2, 8'h77);
    for (int k = 0; k < RST_N; k++) tick();
    rdAddr = 3'd7;
    tick();
    chk("R9 status after busy", 64'(rdData), 64'h50);
    readChk(3'd2, 8'h01, "R10 srst count signature");
    readChk(3'd6, 8'hA0, "R10 srst devhead");
    blkWr(3'd6, 8'h10);
    readChk(3'd5, 8'hEB, "R10 packet cyl hi");
    ctlWr(8'h80);
    readChk(3'd4, 8'h00, "R10 srst prev zero");
    tick(); tick();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule